// File: doc/BRIEF.md
# Multi-Channel Segment Reassembly Tracker

This block follows packet framing across many channels that share one receive stream. Every accepted item describes one segment of at most 64 bytes with two status words. The first word gives the channel, the start and end markers, the byte count, a buffer element index and error flags. The low half of the second word is a 16-bit checksum contribution. The block keeps a small state record for each channel in an indexed memory. That record holds a receiving flag, the bytes gathered so far and a running checksum sum. From it the block reports where the segment's data belongs in the packet buffer and how long the packet has become.

A downstream data mover uses the result strobe to place the segment's bytes at the reported offset. At the end marker it hands the finished length and the unfolded sum on. Two kinds of fault stop the block: hard status errors in the first word, and framing faults. A framing fault is a start segment on a channel that is already mid-packet, or a continuation segment on an idle channel. The stop is sticky and holds until reset, so that no corrupted channel state is written.

Top module: `seg_reasm_tracker`

## Requirements
- R1: Status word 0 is decoded as follows. Bits 4:0 are the channel. Bit 15 is start. Bit 14 is end. Bits 23:16 are the byte count. Bits 30:24 are the element index. Bit 10 is a per-segment receive error flag. Channel, start, end, count, element and flag are echoed on the result outputs.
- R2: If any of status word 0 bits 8, 9, 11 or 12 is set, the block raises `halt` with `halt_cause` = 1. It gives no result strobe and changes no channel state. Bit 10 alone does not halt.
- R3: A start segment on a channel that is receiving raises `halt` with `halt_cause` = 2 and gives no result strobe.
- R4: A segment without start on an idle channel raises `halt` with `halt_cause` = 2 and gives no result strobe.
- R5: After a good segment the channel is receiving exactly when the end marker was clear. A segment with both markers therefore leaves the channel idle.
- R6: `out_offset` is 0 for a start segment; otherwise it is the channel's length before this segment. `out_length` is `out_offset` plus the byte count.
- R7: `out_sum` is a 32-bit sum with no end-around carry. It is cleared on a start segment, and status word 1 bits 15:0 are added to it on every segment.
- R8: The 32 channels keep fully independent state when their segments interleave.
- R9: Reset clears `halt`, `halt_cause` and `out_valid`, raises `in_ready`, and returns every channel to idle with zero length and sum.
- R10: A segment is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low in the next cycle. `out_valid` is high for one cycle only, in the cycle after that. While `halt` is high, `in_ready` stays low and input has no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Status words present |
| in_ready | output | 1 | Block can take a segment |
| in_stat0 | input | 32 | Status word 0 (channel, markers, count, element, flags) |
| in_stat1 | input | 32 | Status word 1 (bits 15:0 checksum contribution) |
| out_valid | output | 1 | One-cycle result strobe |
| out_chan | output | 5 | Channel of the result |
| out_sop | output | 1 | Segment started a packet |
| out_eop | output | 1 | Segment ended a packet |
| out_rxerr | output | 1 | Segment receive error flag |
| out_elem | output | 7 | Buffer element index |
| out_bytes | output | 8 | Segment byte count |
| out_offset | output | LEN_W | Write offset into the packet buffer |
| out_length | output | LEN_W | Packet length after this segment |
| out_sum | output | SUM_W | Running checksum sum after this segment |
| halt | output | 1 | Sticky stop |
| halt_cause | output | 2 | 0 none, 1 status error, 2 framing error |

## Verification
The bench builds the block with its default widths: a 16-bit length, a 32-bit sum and the full set of 32 channels. With these values it can drive channel 0 and channel 31 at the two ends of the state memory. A 32-bit sum also lets repeated 0xFFFF words carry past bit 15, so a result that folds or truncates the carry shows up. Interleaved packets on three channels show that the state of each channel stays apart. Directed cases after reset cover each fatal status bit alone, both framing faults, and a start-and-end single segment followed by a continuation.

// File: rtl/seg_reasm_pkg.sv
package seg_reasm_pkg;

  localparam int CHAN_W     = 5;
  localparam int NUM_CHAN   = 1 << CHAN_W;
  localparam int CNT_W      = 8;
  localparam int ELEM_W     = 7;
  localparam int WORD_W     = 16;

  // Bit positions inside status word 0
  localparam int SOP_BIT    = 15;
  localparam int EOP_BIT    = 14;
  localparam int CNT_LSB    = 16;
  localparam int ELEM_LSB   = 24;
  localparam int FLAG_LSB   = 8;
  localparam int FLAG_W     = 5;
  localparam int RXERR_BIT  = 10;

  // Flags in bits 12:8 that stop the block (bit 10 is excluded)
  localparam logic [FLAG_W-1:0] FATAL_MASK = 5'b11011;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              sop;
    logic              eop;
    logic              rxerr;
    logic              fatal;
    logic [CNT_W-1:0]  nbytes;
    logic [ELEM_W-1:0] elem;
  } seg_info_t;

  typedef enum logic [1:0] {
    STOP_NONE    = 2'd0,
    STOP_STATUS  = 2'd1,
    STOP_FRAMING = 2'd2
  } stop_cause_e;

endpackage

// File: rtl/seg_stat_decode.sv
module seg_stat_decode
  import seg_reasm_pkg::*;
(
  input  logic [31:0] stat0,
  output seg_info_t   info
);

  logic [FLAG_W-1:0] flags;
  logic              unused_rsvd;

  assign flags       = stat0[FLAG_LSB +: FLAG_W];
  assign unused_rsvd = stat0[31] ^ stat0[13];

  always_comb begin
    info.chan   = stat0[CHAN_W-1:0];
    info.sop    = stat0[SOP_BIT];
    info.eop    = stat0[EOP_BIT];
    info.rxerr  = stat0[RXERR_BIT];
    info.fatal  = |(flags & FATAL_MASK);
    info.nbytes = stat0[CNT_LSB +: CNT_W];
    info.elem   = stat0[ELEM_LSB +: ELEM_W];
  end

endmodule

// File: rtl/seg_chan_ram.sv
module seg_chan_ram #(
  parameter int AW = 5,
  parameter int W  = 49
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          rd_vld,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  localparam int DEPTH = 1 << AW;

  // Storage without reset so it can map onto block RAM
  logic [W-1:0]     mem [DEPTH];
  // Per-entry written flags: reset makes every channel read as idle
  logic [DEPTH-1:0] written;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      rd_vld  <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      if (re) rd_vld <= written[raddr];
    end
  end

endmodule

// File: rtl/seg_frame_step.sv
module seg_frame_step
  import seg_reasm_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int SUM_W = 32
) (
  input  seg_info_t          info,
  input  logic [WORD_W-1:0]  word,
  input  logic               cur_vld,
  input  logic               cur_recv,
  input  logic [LEN_W-1:0]   cur_len,
  input  logic [SUM_W-1:0]   cur_sum,
  output logic               proto_err,
  output logic               nxt_recv,
  output logic [LEN_W-1:0]   offset,
  output logic [LEN_W-1:0]   nxt_len,
  output logic [SUM_W-1:0]   nxt_sum
);

  logic             recv;
  logic [LEN_W-1:0] base_len;
  logic [SUM_W-1:0] base_sum;

  always_comb begin
    recv      = cur_vld & cur_recv;
    // start must coincide with idle, continuation with receiving
    proto_err = (info.sop == recv);
    base_len  = (info.sop || !cur_vld) ? '0 : cur_len;
    base_sum  = (info.sop || !cur_vld) ? '0 : cur_sum;
    offset    = base_len;
    nxt_len   = base_len + LEN_W'(info.nbytes);
    nxt_sum   = base_sum + SUM_W'(word);
    nxt_recv  = ~info.eop;
  end

endmodule

// File: rtl/seg_reasm_tracker.sv
module seg_reasm_tracker
  import seg_reasm_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int SUM_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_stat0,
  input  logic [31:0]          in_stat1,
  output logic                 out_valid,
  output logic [CHAN_W-1:0]    out_chan,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic                 out_rxerr,
  output logic [ELEM_W-1:0]    out_elem,
  output logic [CNT_W-1:0]     out_bytes,
  output logic [LEN_W-1:0]     out_offset,
  output logic [LEN_W-1:0]     out_length,
  output logic [SUM_W-1:0]     out_sum,
  output logic                 halt,
  output logic [1:0]           halt_cause
);

  localparam int ENT_W = 1 + LEN_W + SUM_W;

  seg_info_t         dec_info;
  seg_info_t         s_info;
  logic [WORD_W-1:0] s_word;
  logic              busy;
  logic              take;
  logic              commit;
  logic              unused_hi;

  logic [ENT_W-1:0]  rd_ent;
  logic              rd_vld;
  logic [ENT_W-1:0]  wr_ent;

  logic              cur_recv;
  logic [LEN_W-1:0]  cur_len;
  logic [SUM_W-1:0]  cur_sum;
  logic              proto_err;
  logic              nxt_recv;
  logic [LEN_W-1:0]  offset;
  logic [LEN_W-1:0]  nxt_len;
  logic [SUM_W-1:0]  nxt_sum;

  assign unused_hi = ^in_stat1[31:WORD_W];

  seg_stat_decode u_decode (
    .stat0 (in_stat0),
    .info  (dec_info)
  );

  assign in_ready = ~busy & ~halt;
  assign take     = in_valid & in_ready;

  // Stage: capture the accepted segment while the channel record is read
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      s_info <= '0;
      s_word <= '0;
    end else begin
      busy <= take;
      if (take) begin
        s_info <= dec_info;
        s_word <= in_stat1[WORD_W-1:0];
      end
    end
  end

  seg_chan_ram #(
    .AW (CHAN_W),
    .W  (ENT_W)
  ) u_ram (
    .clk    (clk),
    .rst    (rst),
    .re     (take),
    .raddr  (dec_info.chan),
    .rdata  (rd_ent),
    .rd_vld (rd_vld),
    .we     (commit),
    .waddr  (s_info.chan),
    .wdata  (wr_ent)
  );

  assign {cur_recv, cur_len, cur_sum} = rd_ent;

  seg_frame_step #(
    .LEN_W (LEN_W),
    .SUM_W (SUM_W)
  ) u_step (
    .info      (s_info),
    .word      (s_word),
    .cur_vld   (rd_vld),
    .cur_recv  (cur_recv),
    .cur_len   (cur_len),
    .cur_sum   (cur_sum),
    .proto_err (proto_err),
    .nxt_recv  (nxt_recv),
    .offset    (offset),
    .nxt_len   (nxt_len),
    .nxt_sum   (nxt_sum)
  );

  assign wr_ent = {nxt_recv, nxt_len, nxt_sum};
  assign commit = busy & ~s_info.fatal & ~proto_err;

  // Sticky stop
  always_ff @(posedge clk) begin
    if (rst) begin
      halt       <= 1'b0;
      halt_cause <= STOP_NONE;
    end else if (busy && s_info.fatal) begin
      halt       <= 1'b1;
      halt_cause <= STOP_STATUS;
    end else if (busy && proto_err) begin
      halt       <= 1'b1;
      halt_cause <= STOP_FRAMING;
    end
  end

  // Registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_rxerr  <= 1'b0;
      out_elem   <= '0;
      out_bytes  <= '0;
      out_offset <= '0;
      out_length <= '0;
      out_sum    <= '0;
    end else begin
      out_valid <= commit;
      if (commit) begin
        out_chan   <= s_info.chan;
        out_sop    <= s_info.sop;
        out_eop    <= s_info.eop;
        out_rxerr  <= s_info.rxerr;
        out_elem   <= s_info.elem;
        out_bytes  <= s_info.nbytes;
        out_offset <= offset;
        out_length <= nxt_len;
        out_sum    <= nxt_sum;
      end
    end
  end

  // R10: the stop holds until reset
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R10: nothing is taken while stopped
  a_r10_no_take_halted: assert property (@(posedge clk) disable iff (rst)
    halt |-> !in_ready);

  // R10: result strobe lasts one cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R10: no results once stopped
  a_r10_silent_halted: assert property (@(posedge clk) disable iff (rst)
    halt |=> !out_valid);

  // R2: a fatal status flag stops the block with cause 1
  a_r2_status_halts: assert property (@(posedge clk) disable iff (rst)
    (busy && s_info.fatal) |=> (halt && halt_cause == 2'd1 && !out_valid));

  // R6: a start segment writes at offset zero
  a_r6_sop_offset_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop) |-> (out_offset == '0));

  // R6: length is offset plus count
  a_r6_length_sum: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_length == LEN_W'(out_offset + LEN_W'(out_bytes))));

endmodule

// File: tb/seg_reasm_tracker_bench.sv
module seg_reasm_tracker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_stat0 = '0;
  logic [31:0] in_stat1 = '0;
  logic        out_valid;
  logic [4:0]  out_chan;
  logic        out_sop;
  logic        out_eop;
  logic        out_rxerr;
  logic [6:0]  out_elem;
  logic [7:0]  out_bytes;
  logic [15:0] out_offset;
  logic [15:0] out_length;
  logic [31:0] out_sum;
  logic        halt;
  logic [1:0]  halt_cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  seg_reasm_tracker u_seg_reasm_tracker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_stat0   (in_stat0),
    .in_stat1   (in_stat1),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_rxerr  (out_rxerr),
    .out_elem   (out_elem),
    .out_bytes  (out_bytes),
    .out_offset (out_offset),
    .out_length (out_length),
    .out_sum    (out_sum),
    .halt       (halt),
    .halt_cause (halt_cause)
  );

  typedef struct packed {
    logic [4:0]  ch;
    logic        sop;
    logic        eop;
    logic        rxe;
    logic [7:0]  nb;
    logic [15:0] w;
    logic [15:0] off;
    logic [15:0] len;
    logic [31:0] sum;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TAB [NV] = '{
    '{5'd3,  1'b1, 1'b0, 1'b0, 8'd64, 16'h1234, 16'd0,   16'd64,  32'h0000_1234},
    '{5'd7,  1'b1, 1'b1, 1'b0, 8'd20, 16'h0001, 16'd0,   16'd20,  32'h0000_0001},
    '{5'd3,  1'b0, 1'b0, 1'b0, 8'd64, 16'hFFFF, 16'd64,  16'd128, 32'h0001_1233},
    '{5'd7,  1'b1, 1'b0, 1'b0, 8'd10, 16'hFFFF, 16'd0,   16'd10,  32'h0000_FFFF},
    '{5'd3,  1'b0, 1'b0, 1'b1, 8'd64, 16'hFFFF, 16'd128, 16'd192, 32'h0002_1232},
    '{5'd7,  1'b0, 1'b1, 1'b0, 8'd5,  16'h0002, 16'd10,  16'd15,  32'h0001_0001},
    '{5'd3,  1'b0, 1'b1, 1'b0, 8'd1,  16'h8000, 16'd192, 16'd193, 32'h0002_9232},
    '{5'd3,  1'b1, 1'b1, 1'b0, 8'd64, 16'h0005, 16'd0,   16'd64,  32'h0000_0005},
    '{5'd31, 1'b1, 1'b0, 1'b0, 8'd64, 16'hFFFF, 16'd0,   16'd64,  32'h0000_FFFF},
    '{5'd0,  1'b1, 1'b1, 1'b0, 8'd1,  16'h0000, 16'd0,   16'd1,   32'h0000_0000}
  };

  function automatic logic [31:0] mk0(input logic [4:0] ch, input logic sop,
                                      input logic eop, input logic rxe,
                                      input logic [7:0] nb, input logic [6:0] el,
                                      input logic [4:0] flags);
    logic [31:0] v;
    v = '0;
    v[4:0]   = ch;
    v[12:8]  = flags;
    v[10]    = v[10] | rxe;
    v[15]    = sop;
    v[14]    = eop;
    v[23:16] = nb;
    v[30:24] = el;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Called at a falling edge; returns at the falling edge after the result cycle
  task automatic send(input logic [31:0] s0, input logic [31:0] s1);
    in_valid = 1'b1;
    in_stat0 = s0;
    in_stat1 = s1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0 || halt, "R10", "ready low after take", 32'(in_ready), 32'd0);
    @(negedge clk);
  endtask

  task automatic expect_stop(input string req, input logic [1:0] cause);
    chk(halt == 1'b1, req, "halt", 32'(halt), 32'd1);
    chk(halt_cause == cause, req, "halt_cause", 32'(halt_cause), 32'(cause));
    chk(out_valid == 1'b0, req, "no strobe on error", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: reset state
    chk(halt == 1'b0, "R9", "halt after reset", 32'(halt), 32'd0);
    chk(halt_cause == 2'd0, "R9", "cause after reset", 32'(halt_cause), 32'd0);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", 32'(in_ready), 32'd1);

    // Table walk: interleaved channels (R1, R5, R6, R7, R8, R2 bit 10 alone)
    for (int i = 0; i < NV; i++) begin
      send(mk0(TAB[i].ch, TAB[i].sop, TAB[i].eop, TAB[i].rxe, TAB[i].nb, 7'(i), 5'd0),
           {16'hA5A5, TAB[i].w});
      chk(out_valid == 1'b1, "R10", "strobe", 32'(out_valid), 32'd1);
      chk(halt == 1'b0, "R2", "no halt", 32'(halt), 32'd0);
      chk(out_chan == TAB[i].ch, "R8", "channel", 32'(out_chan), 32'(TAB[i].ch));
      chk(out_elem == 7'(i), "R1", "element", 32'(out_elem), 32'(i));
      chk(out_eop == TAB[i].eop && out_sop == TAB[i].sop, "R1", "markers",
          32'({out_sop, out_eop}), 32'({TAB[i].sop, TAB[i].eop}));
      chk(out_rxerr == TAB[i].rxe, "R1", "rx error flag", 32'(out_rxerr), 32'(TAB[i].rxe));
      chk(out_bytes == TAB[i].nb, "R1", "byte count", 32'(out_bytes), 32'(TAB[i].nb));
      chk(out_offset == TAB[i].off, "R6", "offset", 32'(out_offset), 32'(TAB[i].off));
      chk(out_length == TAB[i].len, "R6", "length", 32'(out_length), 32'(TAB[i].len));
      chk(out_sum == TAB[i].sum, "R7", "sum", out_sum, TAB[i].sum);
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "strobe one cycle", 32'(out_valid), 32'd0);

    // R3: channel 31 is mid-packet, a new start is a framing fault
    send(mk0(5'd31, 1'b1, 1'b0, 1'b0, 8'd8, 7'd1, 5'd0), 32'h1);
    expect_stop("R3", 2'd2);

    // R10: input while stopped is ignored
    in_valid = 1'b1;
    in_stat0 = mk0(5'd5, 1'b1, 1'b1, 1'b0, 8'd4, 7'd2, 5'd0);
    repeat (4) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R10", "ready low while halted", 32'(in_ready), 32'd0);
      chk(out_valid == 1'b0, "R10", "no strobe while halted", 32'(out_valid), 32'd0);
    end
    in_valid = 1'b0;

    // R9 and R4: reset clears channel 31, so a continuation is now a fault
    do_reset();
    chk(halt == 1'b0, "R9", "halt cleared", 32'(halt), 32'd0);
    send(mk0(5'd31, 1'b0, 1'b1, 1'b0, 8'd8, 7'd3, 5'd0), 32'h1);
    expect_stop("R4", 2'd2);

    // R5: a start-and-end segment leaves the channel idle
    do_reset();
    send(mk0(5'd9, 1'b1, 1'b1, 1'b0, 8'd12, 7'd4, 5'd0), 32'h7);
    chk(out_valid == 1'b1 && out_length == 16'd12, "R5", "single segment",
        32'(out_length), 32'd12);
    send(mk0(5'd9, 1'b0, 1'b0, 1'b0, 8'd12, 7'd5, 5'd0), 32'h7);
    expect_stop("R5", 2'd2);

    // R2: each fatal flag on its own, on a start segment for an idle channel
    for (int b = 0; b < 5; b++) begin
      if (b != 2) begin
        do_reset();
        send(mk0(5'd1, 1'b1, 1'b0, 1'b0, 8'd16, 7'd6, 5'(1 << b)), 32'h3);
        expect_stop("R2", 2'd1);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule